// File: doc/BRIEF.md
# SDRAM Command and Power-State Tracker

This block watches the command pins of a DDR SDRAM from the controller side. On every rising clock edge it samples clock enable, chip select, the three strobe lines, the two bank-select bits and the twelve address bits. From these samples it works out which command was issued and keeps a copy of the device state that the command implies: which of the four banks hold an open row and which row that is, the contents of the normal and extended mode registers, and whether the device is running, in self-refresh or powered down.

Clock enable is compared with its value one cycle earlier, because the same strobe pattern means different things depending on whether clock enable holds, falls or rises. A command that the device would reject is still reported, but it raises an illegal flag and leaves the tracked state unchanged. A clock-enable level that lasts for only a single sampled edge is reported on a separate violation output. All outputs are registered and change on the edge where the inputs are sampled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With CKE high on this edge and the previous one and the strobes RAS low, CAS high, WE high with chip select low, `cmd_code` becomes 1, the bank selected by {BA1,BA0} (00 bank 0, 01 bank 1, 10 bank 2, 11 bank 3) is marked open, and address bits 11..0 are stored as that bank's row at bits [12*bank+11 : 12*bank] of `bank_row`.
- R2: RAS low, CAS high, WE low with address bit 10 low gives `cmd_code` 2 and closes only the selected bank.
- R3: The same strobes with address bit 10 high give `cmd_code` 3 and close all four banks.
- R4: RAS, CAS and WE all low give a mode-register load of {BA1,BA0,A11..A0} into `mode_reg` with code 7 when BA0 is low, or into `ext_mode_reg` with code 8 when BA0 is high.
- R5: RAS low, CAS low, WE high with CKE high on both edges is an auto-refresh, code 4; the power state stays 0 (running).
- R6: From running, with CKE high on the previous edge and low now, the refresh strobes give code 5 and power state 1 (self-refresh); NOP or deselect gives code 6 and power state 2 (power-down); any other command gives code 10 and raises `illegal`.
- R7: In power state 1 or 2, CKE low on the previous edge and high now with NOP or deselect gives code 9 and returns to state 0; any other command in that cycle gives code 11, raises `illegal` and keeps the state.
- R8: Auto-refresh, self-refresh entry and either mode-register load while any bank is open raise `illegal` and change neither banks, mode registers nor power state.
- R9: In power state 1 or 2, every input other than a valid exit gives code 11 and leaves banks and mode registers unchanged.
- R10: `cke_violation` is 1 for the cycle after an edge where CKE differs from the previous sample while that sample also differed from the one before it.
- R11: During reset all outputs are 0 and the previous CKE samples count as high.
- R12: Chip select high or all strobes high with CKE high on both edges gives code 0; any other encoding gives code 10 with no effect; `cmd_bank` always shows the sampled {BA1,BA0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable as seen at the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select {BA1,BA0} |
| addr | input | 12 | Address bits 11..0 |
| cmd_code | output | 4 | Decoded command of the last sampled edge |
| cmd_bank | output | 2 | Bank select of the last sampled edge |
| bank_open | output | 4 | One open flag per bank |
| bank_row | output | 48 | Latched row per bank, 12 bits each |
| mode_reg | output | 14 | Normal mode register image |
| ext_mode_reg | output | 14 | Extended mode register image |
| pwr_state | output | 2 | 0 running, 1 self-refresh, 2 power-down |
| illegal | output | 1 | Last command broke a state rule |
| cke_violation | output | 1 | Clock-enable level held too briefly |

## Verification
On every cycle the assertions check that an activate leaves its bank open, that a legal precharge closes its bank or all banks, that self-refresh is only ever entered with all banks closed, that an illegal mode load leaves both images untouched, that banks and mode images stay frozen while the device remains in a low-power state, and that a return to running only follows a rising clock enable. The exact command codes chosen for each clock-enable history, the stored row values, the mode register contents and the timing of the clock-enable violation pulse are only shown by the bench, which runs directed sequences through every power transition and long random command streams against its own model.

// File: rtl/sdt_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes: command codes are visible at the top port as a 4-bit number.
package sdt_pkg;
    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_PRE   = 4'd2,
        CMD_PALL  = 4'd3,
        CMD_REF   = 4'd4,
        CMD_SELF  = 4'd5,
        CMD_PDEN  = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_EMRS  = 4'd8,
        CMD_EXIT  = 4'd9,
        CMD_OTHER = 4'd10,
        CMD_IGN   = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_SREF = 2'd1,
        PWR_PDN  = 2'd2
    } pwr_e;
endpackage

// File: rtl/sdt_cmd_decode.sv
// Combinational command decoder.
// Classifies the sampled pins using the current and previous CKE level and
// the power state, and decides whether the command may take effect.
// Assumes: any_open reflects the bank table before this edge.
module sdt_cmd_decode
    import sdt_pkg::*;
(
    input  logic cke,
    input  logic cke_d1,
    input  pwr_e pwr,
    input  logic any_open,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic ba0,
    output cmd_e code,
    output logic bad,
    output logic exec
);
    logic nop_enc;
    logic ref_enc;

    assign nop_enc = cs_n || (ras_n && cas_n && we_n);
    assign ref_enc = !cs_n && !ras_n && !cas_n && we_n;
    assign exec    = !bad;

    // Map pins plus CKE history to a command code and a legality verdict.
    always_comb begin
        code = CMD_NOP;
        bad  = 1'b0;
        if (pwr != PWR_ON) begin
            if (!cke_d1 && cke) begin
                code = nop_enc ? CMD_EXIT : CMD_IGN;
                bad  = !nop_enc;
            end else begin
                code = CMD_IGN;
            end
        end else if (!cke_d1) begin
            code = CMD_IGN;
        end else if (!cke) begin
            if (ref_enc) begin
                code = CMD_SELF;
                bad  = any_open;
            end else if (nop_enc) begin
                code = CMD_PDEN;
            end else begin
                code = CMD_OTHER;
                bad  = 1'b1;
            end
        end else if (nop_enc) begin
            code = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  code = CMD_ACT;
                3'b010:  code = a10 ? CMD_PALL : CMD_PRE;
                3'b001: begin
                    code = CMD_REF;
                    bad  = any_open;
                end
                3'b000: begin
                    code = ba0 ? CMD_EMRS : CMD_MRS;
                    bad  = any_open;
                end
                default: code = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/sdt_power_ctl.sv
// Power-state register and clock-enable history.
// Keeps two past CKE samples, moves between running, self-refresh and
// power-down, and flags a CKE level that was seen on one edge only.
// Assumes: code/exec come from the decoder for the current edge.
module sdt_power_ctl
    import sdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  cmd_e code,
    input  logic exec,
    output pwr_e pwr,
    output logic cke_d1,
    output logic cke_violation
);
    logic cke_d2;

    // Shift the CKE history; reset treats the past as high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_d1 <= 1'b1;
            cke_d2 <= 1'b1;
        end else begin
            cke_d1 <= cke;
            cke_d2 <= cke_d1;
        end
    end

    // Flag a level that changed again one edge after it appeared.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_violation <= 1'b0;
        else        cke_violation <= (cke != cke_d1) && (cke_d1 != cke_d2);
    end

    // Advance the power state on legal entry and exit commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr <= PWR_ON;
        end else if (exec) begin
            case (code)
                CMD_SELF: pwr <= PWR_SREF;
                CMD_PDEN: pwr <= PWR_PDN;
                CMD_EXIT: pwr <= PWR_ON;
                default:  pwr <= pwr;
            endcase
        end
    end

    AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr) != PWR_ON && pwr == PWR_ON) |-> ($past(cke) && !$past(cke_d1))); // R7
endmodule

// File: rtl/sdt_bank_table.sv
// Per-bank open flag and row latch.
// One register slice per bank; activate opens and stores the row, precharge
// closes one bank, precharge-all and self-refresh entry close every bank.
// Assumes: exec is low for any command that must not take effect.
module sdt_bank_table
    import sdt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cmd_e                       code,
    input  logic                       exec,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic             sel;

        assign sel = (ba == BA_W'(g));
        assign bank_open[g] = open_r;
        assign bank_row[g*ROW_W +: ROW_W] = row_r;

        // Update this bank's flag and row from the executed command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (exec) begin
                if (code == CMD_ACT && sel) begin
                    open_r <= 1'b1;
                    row_r  <= addr;
                end else if (code == CMD_PRE && sel) begin
                    open_r <= 1'b0;
                end else if (code == CMD_PALL || code == CMD_SELF) begin
                    open_r <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top of the SDRAM command and power-state tracker.
// Samples the command pins every edge, decodes with CKE history, updates
// bank, mode-register and power state, and registers the decoded command.
// Assumes: pins are already synchronous to clk.
module sdram_cmd_tracker
    import sdt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int PALL_BIT  = 10,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int MODE_W   = BA_W + ROW_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 cmd_code,
    output logic [BA_W-1:0]            cmd_bank,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic [MODE_W-1:0]          mode_reg,
    output logic [MODE_W-1:0]          ext_mode_reg,
    output logic [1:0]                 pwr_state,
    output logic                       illegal,
    output logic                       cke_violation
);
    cmd_e dec_code;
    logic dec_bad;
    logic dec_exec;
    logic cke_d1;
    pwr_e pwr;

    sdt_cmd_decode u_dec (
        .cke      (cke),
        .cke_d1   (cke_d1),
        .pwr      (pwr),
        .any_open (|bank_open),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (addr[PALL_BIT]),
        .ba0      (ba[0]),
        .code     (dec_code),
        .bad      (dec_bad),
        .exec     (dec_exec)
    );

    sdt_power_ctl u_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cke           (cke),
        .code          (dec_code),
        .exec          (dec_exec),
        .pwr           (pwr),
        .cke_d1        (cke_d1),
        .cke_violation (cke_violation)
    );

    sdt_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (dec_code),
        .exec      (dec_exec),
        .ba        (ba),
        .addr      (addr),
        .bank_open (bank_open),
        .bank_row  (bank_row)
    );

    assign pwr_state = pwr;

    // Register the decoded command, its bank and its legality.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= 4'd0;
            cmd_bank <= '0;
            illegal  <= 1'b0;
        end else begin
            cmd_code <= dec_code;
            cmd_bank <= ba;
            illegal  <= dec_bad;
        end
    end

    // Load the selected mode register image on a legal load command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_reg     <= '0;
            ext_mode_reg <= '0;
        end else if (dec_exec && dec_code == CMD_MRS) begin
            mode_reg     <= {ba, addr};
        end else if (dec_exec && dec_code == CMD_EMRS) begin
            ext_mode_reg <= {ba, addr};
        end
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT) |-> bank_open[cmd_bank]); // R1
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_PRE && !illegal) |-> !bank_open[cmd_bank]); // R2
    AST_PALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_PALL) |-> (bank_open == '0)); // R3
    AST_SREF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_SREF && $past(pwr_state) != PWR_SREF) |-> (bank_open == '0)); // R8
    AST_BAD_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && (cmd_code == CMD_MRS || cmd_code == CMD_EMRS))
            |-> ($stable(mode_reg) && $stable(ext_mode_reg))); // R8
    AST_LOWPWR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PWR_ON && $past(pwr_state) == pwr_state)
            |-> ($stable(bank_open) && $stable(bank_row) && $stable(mode_reg))); // R9
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [3:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [3:0]  bank_open;
    logic [47:0] bank_row;
    logic [13:0] mode_reg, ext_mode_reg;
    logic [1:0]  pwr_state;
    logic        illegal, cke_violation;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    int          m_pwr;
    bit [3:0]    m_open;
    logic [11:0] m_row [4];
    logic [13:0] m_mr, m_emr;
    bit          m_d1, m_d2;
    int          e_code;
    bit          e_ill, e_vio;
    logic [1:0]  e_bank;

    always #2 clk = ~clk;

    sdram_cmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .bank_open(bank_open),
        .bank_row(bank_row), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
        .pwr_state(pwr_state), .illegal(illegal), .cke_violation(cke_violation)
    );

    function automatic string req_of(int c);
        case (c)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R5";
            5, 6: return "R6";
            7, 8: return "R4";
            9: return "R7";
            11: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pwr = 0; m_open = 0; m_mr = 0; m_emr = 0; m_d1 = 1; m_d2 = 1;
        for (int k = 0; k < 4; k++) m_row[k] = 0;
    endtask

    // Expected behaviour taken from the requirements.
    task automatic model(input bit ck, input bit cs, input bit r, input bit c, input bit w,
                         input logic [1:0] b, input logic [11:0] a);
        bit nop, refe, anyo, ex;
        int code;
        bit bad;
        nop  = cs || (r && c && w);
        refe = !cs && !r && !c && w;
        anyo = (m_open != 0);
        code = 0; bad = 0;
        if (m_pwr != 0) begin
            if (!m_d1 && ck) begin code = nop ? 9 : 11; bad = !nop; end
            else code = 11;
        end else if (!m_d1) code = 11;
        else if (!ck) begin
            if (refe) begin code = 5; bad = anyo; end
            else if (nop) code = 6;
            else begin code = 10; bad = 1; end
        end else if (nop) code = 0;
        else if (!cs && !r && c && w) code = 1;
        else if (!cs && !r && c && !w) code = a[10] ? 3 : 2;
        else if (refe) begin code = 4; bad = anyo; end
        else if (!cs && !r && !c && !w) begin code = b[0] ? 8 : 7; bad = anyo; end
        else code = 10;
        ex = !bad;
        e_vio = (ck != m_d1) && (m_d1 != m_d2);
        if (ex) begin
            case (code)
                1: begin m_open[b] = 1; m_row[b] = a; end
                2: m_open[b] = 0;
                3: m_open = 0;
                5: begin m_open = 0; m_pwr = 1; end
                6: m_pwr = 2;
                9: m_pwr = 0;
                7: m_mr = {b, a};
                8: m_emr = {b, a};
                default: ;
            endcase
        end
        m_d2 = m_d1; m_d1 = ck;
        e_code = code; e_ill = bad; e_bank = b;
    endtask

    task automatic compare_all();
        logic [47:0] rows;
        string rq;
        for (int k = 0; k < 4; k++) rows[k*12 +: 12] = m_row[k];
        rq = req_of(e_code);
        check(rq, "cmd_code", cmd_code, e_code);
        check("R12", "cmd_bank", cmd_bank, e_bank);
        check("R8", "illegal", illegal, e_ill);
        check(rq, "bank_open", bank_open, m_open);
        check("R1", "bank_row", bank_row, rows);
        check("R4", "mode_reg", mode_reg, m_mr);
        check("R4", "ext_mode_reg", ext_mode_reg, m_emr);
        check(rq, "pwr_state", pwr_state, m_pwr);
        check("R10", "cke_violation", cke_violation, e_vio);
    endtask

    task automatic step(input bit ck, input bit cs, input bit r, input bit c, input bit w,
                        input logic [1:0] b, input logic [11:0] a);
        @(negedge clk);
        cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
        @(posedge clk);
        #1;
        model(ck, cs, r, c, w, b, a);
        compare_all();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11", "reset cmd_code", cmd_code, 0);
        check("R11", "reset bank_open", bank_open, 0);
        check("R11", "reset pwr_state", pwr_state, 0);
        check("R11", "reset mode_reg", {mode_reg, ext_mode_reg}, 0);
        check("R11", "reset flags", {illegal, cke_violation}, 0);
        @(negedge clk);
        rst_n = 1;

        step(1, 0, 0, 1, 1, 2'd2, 12'hABC);   // R1 activate bank 2
        step(1, 0, 0, 1, 1, 2'd1, 12'h123);   // R1 activate bank 1
        step(1, 0, 0, 1, 0, 2'd2, 12'h000);   // R2 precharge bank 2 only
        step(1, 0, 0, 0, 1, 2'd0, 12'h000);   // R8 refresh with bank open
        step(1, 0, 0, 0, 0, 2'd0, 12'h055);   // R8 mode load with bank open
        step(1, 0, 1, 1, 1, 2'd0, 12'h000);   // R12 nop
        step(1, 0, 1, 0, 1, 2'd3, 12'h000);   // R12 other encoding
        step(1, 0, 0, 1, 0, 2'd0, 12'h400);   // R3 precharge all
        step(1, 0, 0, 0, 0, 2'd0, 12'h031);   // R4 normal mode register
        step(1, 0, 0, 0, 0, 2'd1, 12'h002);   // R4 extended mode register
        step(1, 0, 0, 0, 1, 2'd0, 12'h000);   // R5 auto refresh
        step(0, 0, 0, 0, 1, 2'd0, 12'h000);   // R6 self-refresh entry
        step(0, 0, 0, 1, 1, 2'd3, 12'hFFF);   // R9 ignored activate
        step(0, 0, 0, 0, 0, 2'd0, 12'h777);   // R9 ignored mode load
        step(1, 0, 0, 1, 1, 2'd0, 12'h111);   // R7 rising CKE with bad command
        step(0, 1, 1, 1, 1, 2'd0, 12'h000);   // R10 pulse back low
        step(0, 1, 1, 1, 1, 2'd0, 12'h000);
        step(1, 1, 1, 1, 1, 2'd0, 12'h000);   // R7 exit
        step(1, 0, 0, 1, 1, 2'd0, 12'h0F0);   // R1 open bank 0
        step(0, 1, 1, 1, 1, 2'd0, 12'h000);   // R6 power-down entry
        step(0, 0, 1, 1, 0, 2'd0, 12'h000);   // R9 ignored
        step(1, 0, 1, 1, 1, 2'd0, 12'h000);   // R7 exit with nop
        step(0, 0, 0, 0, 1, 2'd0, 12'h000);   // R8 self-refresh with bank open
        step(1, 1, 1, 1, 1, 2'd0, 12'h000);
        step(0, 1, 1, 1, 1, 2'd0, 12'h000);   // R10 single-cycle low
        step(1, 1, 1, 1, 1, 2'd0, 12'h000);
        step(1, 1, 1, 1, 1, 2'd0, 12'h000);

        for (int i = 0; i < 6000; i++) begin
            bit ck;
            int sel;
            logic [1:0] b;
            logic [11:0] a;
            ck = cke;
            if ($urandom_range(0, 9) == 0) ck = !ck;
            b = 2'($urandom);
            a = 12'($urandom);
            sel = $urandom_range(0, 11);
            case (sel)
                0, 1: step(ck, 0, 0, 1, 1, b, a);
                2:    step(ck, 0, 0, 1, 0, b, a & 12'hBFF);
                3:    step(ck, 0, 0, 1, 0, b, a | 12'h400);
                4, 5: step(ck, 0, 0, 0, 1, b, a);
                6:    step(ck, 0, 0, 0, 0, b, a);
                7:    step(ck, 0, 1, 0, 1, b, a);
                8, 9: step(ck, 0, 1, 1, 1, b, a);
                default: step(ck, 1, 1'($urandom), 1'($urandom), 1'($urandom), b, a);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule